// File: doc/BRIEF.md
# Cache Line Eviction Writeback Engine

This engine evicts one line from a shared cache so that an incoming victim can take its place. When the replacement logic presents a valid line, the engine invalidates that line in the same cycle and keeps its data and dirty bit in a single transaction buffer. It then sends the directory a victim message that carries the buffered data. A line that was modified or owned goes out as a dirty victim. A line that was exclusive or shared goes out as a clean victim. The engine then waits for the directory's writeback acknowledge.

While it waits, the engine resolves races with the rest of the coherence system. Probes are answered from the buffer or without data. An invalidating probe moves the engine into a cancel state, where it only waits for the acknowledge. A victim written back by another agent during a dirty eviction is acknowledged and tracked through two drop-data states. In those states the late data is discarded and the directory is unblocked with a not-valid indication. Only one eviction is outstanding at a time. Choosing the set and the way is left to the surrounding cache.

Top module: `victim_evict_engine`

## Requirements
- R1: After reset the engine is idle: busy=0, evict_ready=1, wait_src=SELF_ID (default 4'hA), and dir_req_valid, prb_rsp_valid, vic_ack and unblock_nv are all 0.
- R2: An eviction trigger accepted in idle with evict_state M (4) or O (3) raises line_inv in the same cycle. In the next cycle it drives one dir_req_valid pulse with dir_req_dirty=1 and dir_req_data equal to the captured data.
- R3: An eviction trigger with evict_state E (2) or S (1) raises line_inv in the same cycle. In the next cycle it drives one dir_req_valid pulse with dir_req_dirty=0 and the captured data.
- R4: An eviction trigger with evict_state I (0), or with an unused code 5 to 7, has no effect: line_inv stays 0, no request is sent and the engine stays idle.
- R5: Only one eviction is outstanding. While busy, evict_ready is 0, and a trigger raises neither line_inv nor a request.
- R6: wb_ack in the dirty wait, the clean wait or the cancel state returns the engine to idle by the next cycle.
- R7: In the dirty wait, an invalidating probe that asks for data (prb_kind 1) is answered with prb_rsp_kind 2 (data), carrying the buffered data and dirty bit. A plain invalidating probe (prb_kind 0) is answered with prb_rsp_kind 0 (invalidate, no data). Both move the engine to cancel. Every probe response appears one cycle after the probe.
- R8: In the clean wait, probe kinds 0 and 1 are both answered with prb_rsp_kind 0 and move the engine to cancel.
- R9: A sharing probe (prb_kind 2) in either wait state is answered with prb_rsp_kind 2 and the buffered data and dirty bit, and the state does not change.
- R10: In the cancel state, probe kinds 0 and 1 are answered with prb_rsp_kind 0, a sharing probe gets prb_rsp_kind 1 (miss), and vic_ready is 0 so that victims are recycled.
- R11: A victim (vic_valid with vic_ready=1) arriving in the dirty wait is acknowledged with one vic_ack pulse in the next cycle, and its sender appears on wait_src. The engine enters the drop-data state, and wb_ack there moves it to drop-data-invalid. vic_ready is 0 in every other state.
- R12: In drop-data-invalid, vdat_valid (data or a stale notice) is discarded. One unblock_nv pulse follows in the next cycle and the engine returns to idle.
- R13: In drop-data, vdat_valid returns the engine to the dirty wait and resets wait_src to SELF_ID.
- R14: Probes in idle, drop-data or drop-data-invalid, and reserved probe kind 3 in any state, are answered with prb_rsp_kind 1 (miss) and leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evict_valid | input | 1 | Eviction trigger for the chosen way |
| evict_ready | output | 1 | Engine idle and able to take a trigger |
| evict_state | input | 3 | Line state: 0 I, 1 S, 2 E, 3 O, 4 M |
| evict_dirty | input | 1 | Dirty bit of the evicted line |
| evict_data | input | DATA_W | Data of the evicted line |
| line_inv | output | 1 | Invalidate the line in the cache (same cycle) |
| dir_req_valid | output | 1 | Victim message to the directory |
| dir_req_dirty | output | 1 | 1 dirty victim, 0 clean victim |
| dir_req_data | output | DATA_W | Victim data from the buffer |
| wb_ack | input | 1 | Writeback acknowledge from the directory |
| prb_valid | input | 1 | Probe for the evicted line |
| prb_kind | input | 2 | 0 invalidate, 1 invalidate with data, 2 share, 3 reserved |
| prb_rsp_valid | output | 1 | Probe response |
| prb_rsp_kind | output | 2 | 0 invalidate no data, 1 miss, 2 data |
| prb_rsp_data | output | DATA_W | Buffered data on data responses, else 0 |
| prb_rsp_dirty | output | 1 | Buffered dirty bit on data responses, else 0 |
| vic_valid | input | 1 | Victim from another agent for this line |
| vic_src | input | ID_W | Sender of that victim |
| vic_ready | output | 1 | Victim taken this cycle; low means recycle |
| vic_ack | output | 1 | Writeback acknowledge to the victim sender |
| vdat_valid | input | 1 | Victim data or stale notice arriving |
| unblock_nv | output | 1 | Unblock to the directory, marked not valid |
| busy | output | 1 | An eviction is in progress |
| wait_src | output | ID_W | Agent whose writeback is expected |

## Verification
A wrong internal state shows at the ports on the next probe. A sharing probe gets a miss where data was expected, or the reverse. An invalidating probe asking for data gets the wrong response kind, one cycle after it is issued. A state that is stuck or skipped shows at evict_ready or vic_ready in the cycle after the acknowledge or victim that should have moved it, or as a missing or extra unblock_nv or vic_ack pulse. The bench sweeps every line state against every probe kind, each followed by a second probe, a blocked trigger and the acknowledge. This exposes a bad state within two cycles of the first probe.

// File: rtl/vee_pkg.sv
package vee_pkg;

    typedef enum logic [2:0] {
        LS_I = 3'd0,
        LS_S = 3'd1,
        LS_E = 3'd2,
        LS_O = 3'd3,
        LS_M = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        PK_INV      = 2'd0,
        PK_INV_DATA = 2'd1,
        PK_SHARE    = 2'd2,
        PK_RSVD     = 2'd3
    } probe_kind_e;

    typedef enum logic [1:0] {
        PR_INV_NODATA = 2'd0,
        PR_MISS       = 2'd1,
        PR_DATA       = 2'd2
    } probe_rsp_e;

    typedef enum logic [2:0] {
        ES_IDLE,
        ES_DIRTY_WAIT,
        ES_CLEAN_WAIT,
        ES_CANCEL,
        ES_DROP,
        ES_DROP_INV
    } eng_st_e;

    typedef struct packed {
        probe_rsp_e kind;
        logic       to_cancel;
    } probe_dec_t;

    function automatic logic line_is_valid(logic [2:0] s);
        return (s == LS_S) || (s == LS_E) || (s == LS_O) || (s == LS_M);
    endfunction

    function automatic logic line_is_dirty(logic [2:0] s);
        return (s == LS_O) || (s == LS_M);
    endfunction

    function automatic probe_dec_t probe_decide(eng_st_e s, logic [1:0] k);
        probe_dec_t d;
        d.kind      = PR_MISS;
        d.to_cancel = 1'b0;
        if (s == ES_DIRTY_WAIT || s == ES_CLEAN_WAIT) begin
            if (k == PK_INV) begin
                d.kind      = PR_INV_NODATA;
                d.to_cancel = 1'b1;
            end else if (k == PK_INV_DATA) begin
                d.kind      = (s == ES_DIRTY_WAIT) ? PR_DATA : PR_INV_NODATA;
                d.to_cancel = 1'b1;
            end else if (k == PK_SHARE) begin
                d.kind = PR_DATA;
            end
        end else if (s == ES_CANCEL) begin
            if (k == PK_INV || k == PK_INV_DATA) begin
                d.kind = PR_INV_NODATA;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/vee_ctrl.sv
module vee_ctrl
    import vee_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       evict_valid,
    input  logic [2:0] evict_state,
    input  logic       wb_ack,
    input  logic       prb_valid,
    input  logic [1:0] prb_kind,
    input  logic       vic_valid,
    input  logic       vdat_valid,
    output eng_st_e    st,
    output logic       evict_ready,
    output logic       line_inv,
    output logic       vic_ready,
    output logic       take_vic,
    output logic       drop_to_wait,
    output logic       prb_fire,
    output probe_dec_t prb_dec,
    output logic       dir_req_valid,
    output logic       dir_req_dirty,
    output logic       vic_ack,
    output logic       unblock_nv
);

    eng_st_e st_nx;
    logic    prb_ev;
    logic    dat_ev;

    // Event priority within a cycle: acknowledge, probe, victim data, victim.
    always_comb begin
        evict_ready  = (st == ES_IDLE);
        line_inv     = evict_valid && evict_ready && line_is_valid(evict_state);
        prb_ev       = prb_valid && !wb_ack;
        dat_ev       = vdat_valid && !wb_ack && !prb_valid;
        vic_ready    = (st == ES_DIRTY_WAIT) && !wb_ack && !prb_valid && !vdat_valid;
        take_vic     = vic_valid && vic_ready;
        prb_fire     = prb_ev;
        prb_dec      = probe_decide(st, prb_kind);
        drop_to_wait = dat_ev && (st == ES_DROP);
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ES_IDLE: begin
                if (line_inv) begin
                    st_nx = line_is_dirty(evict_state) ? ES_DIRTY_WAIT : ES_CLEAN_WAIT;
                end
            end
            ES_DIRTY_WAIT: begin
                if (wb_ack)                          st_nx = ES_IDLE;
                else if (prb_ev && prb_dec.to_cancel) st_nx = ES_CANCEL;
                else if (take_vic)                   st_nx = ES_DROP;
            end
            ES_CLEAN_WAIT: begin
                if (wb_ack)                          st_nx = ES_IDLE;
                else if (prb_ev && prb_dec.to_cancel) st_nx = ES_CANCEL;
            end
            ES_CANCEL: begin
                if (wb_ack) st_nx = ES_IDLE;
            end
            ES_DROP: begin
                if (wb_ack)      st_nx = ES_DROP_INV;
                else if (dat_ev) st_nx = ES_DIRTY_WAIT;
            end
            ES_DROP_INV: begin
                if (dat_ev) st_nx = ES_IDLE;
            end
            default: st_nx = ES_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= ES_IDLE;
            dir_req_valid <= 1'b0;
            dir_req_dirty <= 1'b0;
            vic_ack       <= 1'b0;
            unblock_nv    <= 1'b0;
        end else begin
            st            <= st_nx;
            dir_req_valid <= line_inv;
            dir_req_dirty <= line_inv && line_is_dirty(evict_state);
            vic_ack       <= take_vic;
            unblock_nv    <= dat_ev && (st == ES_DROP_INV);
        end
    end

endmodule

// File: rtl/vee_buffer.sv
module vee_buffer #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ID_W    = 4,
    parameter int unsigned SELF_ID = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_dirty,
    input  logic              take_vic,
    input  logic [ID_W-1:0]   vic_src,
    input  logic              reset_src,
    output logic [DATA_W-1:0] buf_data,
    output logic              buf_dirty,
    output logic [ID_W-1:0]   buf_src
);

    localparam logic [ID_W-1:0] SELF = ID_W'(SELF_ID);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_data  <= '0;
            buf_dirty <= 1'b0;
            buf_src   <= SELF;
        end else begin
            if (load) begin
                buf_data  <= load_data;
                buf_dirty <= load_dirty;
            end
            if (load || reset_src) begin
                buf_src <= SELF;
            end else if (take_vic) begin
                buf_src <= vic_src;
            end
        end
    end

endmodule

// File: rtl/vee_probe_resp.sv
module vee_probe_resp
    import vee_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  probe_dec_t        dec,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              buf_dirty,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_dirty
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= 2'd0;
            rsp_data  <= '0;
            rsp_dirty <= 1'b0;
        end else begin
            rsp_valid <= fire;
            if (fire) begin
                rsp_kind  <= dec.kind;
                rsp_data  <= (dec.kind == PR_DATA) ? buf_data : '0;
                rsp_dirty <= (dec.kind == PR_DATA) && buf_dirty;
            end
        end
    end

endmodule

// File: rtl/victim_evict_engine.sv
module victim_evict_engine
    import vee_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ID_W    = 4,
    parameter int unsigned SELF_ID = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evict_valid,
    output logic              evict_ready,
    input  logic [2:0]        evict_state,
    input  logic              evict_dirty,
    input  logic [DATA_W-1:0] evict_data,
    output logic              line_inv,
    output logic              dir_req_valid,
    output logic              dir_req_dirty,
    output logic [DATA_W-1:0] dir_req_data,
    input  logic              wb_ack,
    input  logic              prb_valid,
    input  logic [1:0]        prb_kind,
    output logic              prb_rsp_valid,
    output logic [1:0]        prb_rsp_kind,
    output logic [DATA_W-1:0] prb_rsp_data,
    output logic              prb_rsp_dirty,
    input  logic              vic_valid,
    input  logic [ID_W-1:0]   vic_src,
    output logic              vic_ready,
    output logic              vic_ack,
    input  logic              vdat_valid,
    output logic              unblock_nv,
    output logic              busy,
    output logic [ID_W-1:0]   wait_src
);

    eng_st_e           st;
    logic              take_vic;
    logic              drop_to_wait;
    logic              prb_fire;
    probe_dec_t        prb_dec;
    logic [DATA_W-1:0] buf_data;
    logic              buf_dirty;

    vee_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .evict_valid   (evict_valid),
        .evict_state   (evict_state),
        .wb_ack        (wb_ack),
        .prb_valid     (prb_valid),
        .prb_kind      (prb_kind),
        .vic_valid     (vic_valid),
        .vdat_valid    (vdat_valid),
        .st            (st),
        .evict_ready   (evict_ready),
        .line_inv      (line_inv),
        .vic_ready     (vic_ready),
        .take_vic      (take_vic),
        .drop_to_wait  (drop_to_wait),
        .prb_fire      (prb_fire),
        .prb_dec       (prb_dec),
        .dir_req_valid (dir_req_valid),
        .dir_req_dirty (dir_req_dirty),
        .vic_ack       (vic_ack),
        .unblock_nv    (unblock_nv)
    );

    vee_buffer #(
        .DATA_W  (DATA_W),
        .ID_W    (ID_W),
        .SELF_ID (SELF_ID)
    ) u_buf (
        .clk        (clk),
        .rst        (rst),
        .load       (line_inv),
        .load_data  (evict_data),
        .load_dirty (evict_dirty),
        .take_vic   (take_vic),
        .vic_src    (vic_src),
        .reset_src  (drop_to_wait),
        .buf_data   (buf_data),
        .buf_dirty  (buf_dirty),
        .buf_src    (wait_src)
    );

    vee_probe_resp #(
        .DATA_W (DATA_W)
    ) u_prsp (
        .clk       (clk),
        .rst       (rst),
        .fire      (prb_fire),
        .dec       (prb_dec),
        .buf_data  (buf_data),
        .buf_dirty (buf_dirty),
        .rsp_valid (prb_rsp_valid),
        .rsp_kind  (prb_rsp_kind),
        .rsp_data  (prb_rsp_data),
        .rsp_dirty (prb_rsp_dirty)
    );

    assign dir_req_data = buf_data;
    assign busy         = (st != ES_IDLE);

endmodule

// File: rtl/vee_checker.sv
module vee_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ID_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              evict_valid,
    input logic              evict_ready,
    input logic [2:0]        evict_state,
    input logic              line_inv,
    input logic              dir_req_valid,
    input logic              dir_req_dirty,
    input logic              prb_valid,
    input logic              wb_ack,
    input logic              prb_rsp_valid,
    input logic              vic_valid,
    input logic              vic_ready,
    input logic [ID_W-1:0]   vic_src,
    input logic              vic_ack,
    input logic              unblock_nv,
    input logic              busy,
    input logic [ID_W-1:0]   wait_src
);

    p_dirty_victim_r2: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && evict_ready && (evict_state == 3'd3 || evict_state == 3'd4))
        |=> (dir_req_valid && dir_req_dirty));

    p_clean_victim_r3: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && evict_ready && (evict_state == 3'd1 || evict_state == 3'd2))
        |=> (dir_req_valid && !dir_req_dirty));

    p_ignore_invalid_r4: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && (evict_state == 3'd0 || evict_state > 3'd4)) |-> !line_inv);

    p_request_while_busy_r5: assert property (@(posedge clk) disable iff (rst)
        dir_req_valid |-> busy);

    p_busy_after_evict_r5: assert property (@(posedge clk) disable iff (rst)
        line_inv |=> (busy && !evict_ready));

    p_probe_answer_r7: assert property (@(posedge clk) disable iff (rst)
        (prb_valid && !wb_ack) |=> prb_rsp_valid);

    p_victim_ack_r11: assert property (@(posedge clk) disable iff (rst)
        (vic_valid && vic_ready) |=> (vic_ack && wait_src == $past(vic_src)));

    p_unblock_idle_r12: assert property (@(posedge clk) disable iff (rst)
        unblock_nv |-> !busy);

endmodule

bind victim_evict_engine vee_checker #(
    .DATA_W (DATA_W),
    .ID_W   (ID_W)
) u_vee_chk (
    .clk           (clk),
    .rst           (rst),
    .evict_valid   (evict_valid),
    .evict_ready   (evict_ready),
    .evict_state   (evict_state),
    .line_inv      (line_inv),
    .dir_req_valid (dir_req_valid),
    .dir_req_dirty (dir_req_dirty),
    .prb_valid     (prb_valid),
    .wb_ack        (wb_ack),
    .prb_rsp_valid (prb_rsp_valid),
    .vic_valid     (vic_valid),
    .vic_ready     (vic_ready),
    .vic_src       (vic_src),
    .vic_ack       (vic_ack),
    .unblock_nv    (unblock_nv),
    .busy          (busy),
    .wait_src      (wait_src)
);

// File: tb/victim_evict_engine_tb.sv
module victim_evict_engine_tb;

    localparam int DW   = 32;
    localparam int IW   = 4;
    localparam int SELF = 10;

    localparam int K_NODATA = 0;
    localparam int K_MISS   = 1;
    localparam int K_DATA   = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          evict_valid = 1'b0;
    logic          evict_ready;
    logic [2:0]    evict_state = 3'd0;
    logic          evict_dirty = 1'b0;
    logic [DW-1:0] evict_data = '0;
    logic          line_inv;
    logic          dir_req_valid;
    logic          dir_req_dirty;
    logic [DW-1:0] dir_req_data;
    logic          wb_ack = 1'b0;
    logic          prb_valid = 1'b0;
    logic [1:0]    prb_kind = 2'd0;
    logic          prb_rsp_valid;
    logic [1:0]    prb_rsp_kind;
    logic [DW-1:0] prb_rsp_data;
    logic          prb_rsp_dirty;
    logic          vic_valid = 1'b0;
    logic [IW-1:0] vic_src = '0;
    logic          vic_ready;
    logic          vic_ack;
    logic          vdat_valid = 1'b0;
    logic          unblock_nv;
    logic          busy;
    logic [IW-1:0] wait_src;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    victim_evict_engine #(.DATA_W(DW), .ID_W(IW), .SELF_ID(SELF)) u_dut (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Trigger an eviction; returns after the request cycle.
    task automatic evict(input logic [2:0] s, input logic [DW-1:0] d, input logic dd,
                         input string req);
        logic valid;
        valid       = (s >= 3'd1 && s <= 3'd4);
        evict_valid = 1'b1;
        evict_state = s;
        evict_data  = d;
        evict_dirty = dd;
        #1;
        chk(req, "line_inv at trigger", line_inv, valid);
        tick();
        evict_valid = 1'b0;
        chk(req, "dir_req_valid", dir_req_valid, valid);
        if (valid) begin
            chk(req, "dir_req_dirty", dir_req_dirty, (s >= 3'd3));
            chk(req, "dir_req_data", dir_req_data, d);
        end
        chk(req, "busy after trigger", busy, valid);
    endtask

    task automatic probe(input logic [1:0] k, input int ek,
                         input logic [DW-1:0] ed, input logic edirty, input string req);
        prb_valid = 1'b1;
        prb_kind  = k;
        tick();
        prb_valid = 1'b0;
        chk(req, "prb_rsp_valid", prb_rsp_valid, 1);
        chk(req, "prb_rsp_kind", prb_rsp_kind, ek);
        if (ek == K_DATA) begin
            chk(req, "prb_rsp_data", prb_rsp_data, ed);
            chk(req, "prb_rsp_dirty", prb_rsp_dirty, edirty);
        end
    endtask

    task automatic ack_to_idle(input string req);
        wb_ack = 1'b1;
        tick();
        wb_ack = 1'b0;
        chk(req, "evict_ready after ack", evict_ready, 1);
        chk(req, "busy after ack", busy, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "evict_ready", evict_ready, 1);
        chk("R1", "wait_src", wait_src, SELF);
        chk("R1", "dir_req_valid", dir_req_valid, 0);
        chk("R1", "prb_rsp_valid", prb_rsp_valid, 0);
        chk("R1", "vic_ack", vic_ack, 0);
        chk("R1", "unblock_nv", unblock_nv, 0);

        // R4 invalid and unused line state codes
        for (int s = 5; s < 8; s++) begin
            evict(3'(s), 32'h5555_0000 + 32'(s), 1'b1, "R4");
        end

        // Sweep every line state against every probe kind
        for (int s = 0; s < 5; s++) begin
            for (int k = 0; k < 4; k++) begin
                logic [DW-1:0] d;
                logic dd, dw, cancel;
                int ek, ek2;
                d  = 32'hC0DE_0000 | (32'(s) << 8) | 32'(k);
                dd = 1'(s + k);
                evict(3'(s), d, dd, (s >= 3) ? "R2" : ((s == 0) ? "R4" : "R3"));
                if (s == 0) continue;
                dw = (s >= 3);
                // swept probe: R7 dirty wait, R8 clean wait, R9 share, R14 reserved
                case (k)
                    0: begin ek = K_NODATA; cancel = 1; end
                    1: begin ek = dw ? K_DATA : K_NODATA; cancel = 1; end
                    2: begin ek = K_DATA; cancel = 0; end
                    default: begin ek = K_MISS; cancel = 0; end
                endcase
                probe(2'(k), ek, d, dd,
                      (k == 3) ? "R14" : ((k == 2) ? "R9" : (dw ? "R7" : "R8")));
                // follow-up share probe reveals wait or cancel (R9, R10)
                ek2 = cancel ? K_MISS : K_DATA;
                probe(2'd2, ek2, d, dd, cancel ? "R10" : "R9");
                // R5 second trigger while busy
                evict_valid = 1'b1;
                evict_state = 3'd4;
                evict_data  = 32'hFFFF_FFFF;
                #1;
                chk("R5", "evict_ready while busy", evict_ready, 0);
                chk("R5", "line_inv while busy", line_inv, 0);
                tick();
                evict_valid = 1'b0;
                chk("R5", "no request while busy", dir_req_valid, 0);
                // R10/R11 victims recycled unless dirty wait
                if (cancel || !dw) begin
                    vic_valid = 1'b1;
                    vic_src   = 4'h3;
                    #1;
                    chk(cancel ? "R10" : "R11", "vic_ready recycled", vic_ready, 0);
                    tick();
                    vic_valid = 1'b0;
                    chk(cancel ? "R10" : "R11", "no vic_ack", vic_ack, 0);
                end
                if (cancel && k == 1) begin
                    probe(2'd1, K_NODATA, '0, 1'b0, "R10");
                end
                ack_to_idle("R6");
            end
        end

        // R14 probe in idle
        probe(2'd2, K_MISS, '0, 1'b0, "R14");

        // R11, R12: victim during dirty wait then drop-invalid
        evict(3'd4, 32'hA5A5_0001, 1'b1, "R2");
        vic_valid = 1'b1;
        vic_src   = 4'h5;
        #1;
        chk("R11", "vic_ready in dirty wait", vic_ready, 1);
        tick();
        vic_valid = 1'b0;
        chk("R11", "vic_ack", vic_ack, 1);
        chk("R11", "wait_src", wait_src, 5);
        probe(2'd0, K_MISS, '0, 1'b0, "R14");
        wb_ack = 1'b1;
        tick();
        wb_ack = 1'b0;
        chk("R11", "still busy in drop-invalid", busy, 1);
        probe(2'd2, K_MISS, '0, 1'b0, "R14");
        vdat_valid = 1'b1;
        tick();
        vdat_valid = 1'b0;
        chk("R12", "unblock_nv", unblock_nv, 1);
        chk("R12", "idle after drop", busy, 0);
        tick();
        chk("R12", "unblock single pulse", unblock_nv, 0);

        // R13: data in drop-data returns to dirty wait
        evict(3'd3, 32'h0BAD_F00D, 1'b0, "R2");
        vic_valid = 1'b1;
        vic_src   = 4'h7;
        tick();
        vic_valid = 1'b0;
        chk("R11", "wait_src", wait_src, 7);
        vdat_valid = 1'b1;
        tick();
        vdat_valid = 1'b0;
        chk("R13", "wait_src reset", wait_src, SELF);
        chk("R13", "no unblock", unblock_nv, 0);
        probe(2'd2, K_DATA, 32'h0BAD_F00D, 1'b0, "R13");
        ack_to_idle("R6");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule